// File: doc/BRIEF.md
# Decimal Stopwatch Time Counter with Display Freeze

This block keeps elapsed time for a stopwatch as six binary-coded decimal digits: two for minutes, two for seconds and two for hundredths of a second. A chain of decimal prescaler stages divides the 100 kHz system clock by one thousand. This produces one count step every hundredth of a second. That step then walks a chain of six time digits. The tens-of-seconds digit runs from 0 to 5, so the seconds field rolls over at 60. Every other digit runs from 0 to 9.

The block gives two views of the time. The live digits always show the running count. The shown digits feed a display. While the freeze control is high they hold their value, and the live count keeps advancing underneath. A synchronous init and a separate clear both return the count, the prescaler phase and the shown digits to zero. The count enable pauses and resumes timing without losing the prescaler phase. Button filtering, segment decoding and digit multiplexing belong to the surrounding logic.

Top module: `stopwatch_core`

## Requirements
- R1: While `init` is high at a clock edge, every live digit, every shown digit and the prescaler phase become zero at that edge.
- R2: With `run_en` held high after init or clear, the hundredths count first changes on the 10^PRE_STAGES-th enabled edge (1000th by default), and then once every 10^PRE_STAGES enabled edges.
- R3: An edge with `run_en` low changes neither the live digits nor the prescaler phase.
- R4: Digit layout in both 24-bit outputs, four bits per digit: [3:0] hundredths units, [7:4] hundredths tens, [11:8] seconds units, [15:12] seconds tens, [19:16] minutes units, [23:20] minutes tens. A digit steps only on a count step in which every lower digit sits at its last value, and steps from its last value back to 0 (for example, 00:00.99 is followed by 00:01.00).
- R5: The seconds-tens digit counts 0 to 5 only: 00:59.99 is followed by 01:00.00.
- R6: From the highest count (99:59.99 with default parameters, MIN_HI_LAST:MIN_LO_LAST:59.99 in general) the next count step returns all digits to 00:00.00.
- R7: `clr` high at an edge zeroes the live digits, the shown digits and the prescaler phase at that same edge, whatever `run_en` and `lap_hold` are.
- R8: While `lap_hold` is high (and neither `clr` nor `init`), the shown digits keep their value while the live digits go on counting.
- R9: At every edge where `lap_hold` is low, the shown digits take the value the live digits take at that same edge. After a release, they therefore match the live count from the next edge on.
- R10: No digit ever holds a value above its last value (9, 5 for seconds tens, or the minute limits).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (100 kHz in the intended use) |
| init | input | 1 | Synchronous active-high initialisation |
| run_en | input | 1 | Count enable; low pauses timing |
| clr | input | 1 | Synchronous clear of count and shown value |
| lap_hold | input | 1 | High freezes the shown digits |
| live_bcd | output | 24 | Running time, six BCD digits |
| shown_bcd | output | 24 | Displayed time, held while frozen |

## Verification
Assertions check four things on every cycle. Each digit stays in range, and a digit without a carry keeps its value. The shown digits are stable under freeze and track the live digits when not frozen. A clear or a pause takes effect at the stated edge. Only the bench scenarios can show the slower behaviours: the exact thousand-cycle prescaler spacing, the 59.99-to-next-minute and full-range wrap sequences, and the value captured at the moment of a freeze. For these the bench compares both outputs against a behavioural elapsed-time model. It uses a default instance and a second instance with no prescaler and reduced minute limits, so the wrap is reachable.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int DW   = 4;
  localparam int NDIG = 6;
  localparam int OW   = DW * NDIG;

  // last value of each time digit, lowest digit first
  function automatic int unsigned stage_last(int idx, int unsigned lo, int unsigned hi);
    case (idx)
      3:       return 5;
      4:       return lo;
      5:       return hi;
      default: return 9;
    endcase
  endfunction
endpackage

// File: rtl/sw_prescale.sv
module sw_prescale #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic zero,
  input  logic en,
  output logic tick
);
  import sw_pkg::*;

  generate
    if (STAGES == 0) begin : g_bypass
      assign tick = en && !zero;
    end else begin : g_chain
      logic [DW-1:0] pd [STAGES];
      logic [STAGES:0] cy;
      assign cy[0] = en;
      for (genvar i = 0; i < STAGES; i++) begin : g_st
        assign cy[i+1] = cy[i] && (pd[i] == DW'(9));
        always_ff @(posedge clk) begin
          if (zero)       pd[i] <= '0;
          else if (cy[i]) pd[i] <= (pd[i] == DW'(9)) ? '0 : pd[i] + 1'b1;
        end
        // R10: prescaler digits stay decimal
        a_r10_pre_range: assert property (@(posedge clk) disable iff (zero)
          pd[i] <= DW'(9));
      end
      assign tick = cy[STAGES];

      // R2: consecutive count steps are never adjacent
      a_r2_tick_gap: assert property (@(posedge clk) disable iff (zero)
        tick |=> !tick);
      // R3: paused prescaler keeps its phase
      a_r3_pre_hold: assert property (@(posedge clk) disable iff (zero)
        !en |=> $stable(pd[0]));
    end
  endgenerate
endmodule

// File: rtl/sw_digit.sv
module sw_digit #(
  parameter int unsigned LAST = 9
) (
  input  logic                 clk,
  input  logic                 zero,
  input  logic                 step,
  output logic [sw_pkg::DW-1:0] q,
  output logic [sw_pkg::DW-1:0] q_next,
  output logic                 at_last
);
  import sw_pkg::*;
  localparam logic [DW-1:0] LASTV = DW'(LAST);

  always_comb begin
    at_last = (q == LASTV);
    if (zero)       q_next = '0;
    else if (step)  q_next = at_last ? '0 : q + 1'b1;
    else            q_next = q;
  end

  always_ff @(posedge clk) q <= q_next;

  // R10: digit never passes its last value
  a_r10_range: assert property (@(posedge clk) disable iff (zero)
    q <= LASTV);
  // R4: no carry in, no change
  a_r4_idle: assert property (@(posedge clk) disable iff (zero)
    !step |=> $stable(q));
  // R6: a carry at the last value rolls to zero
  a_r6_roll: assert property (@(posedge clk) disable iff (zero)
    (step && at_last) |=> (q == '0));
endmodule

// File: rtl/sw_lap_hold.sv
module sw_lap_hold #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         zero,
  input  logic         freeze,
  input  logic [W-1:0] next_val,
  output logic [W-1:0] shown
);
  always_ff @(posedge clk) begin
    if (zero)         shown <= '0;
    else if (!freeze) shown <= next_val;
  end

  // R8: frozen display does not move
  a_r8_frozen: assert property (@(posedge clk) disable iff (zero)
    freeze |=> $stable(shown));
  // R7: zero request empties the display
  a_r7_zero_shown: assert property (@(posedge clk)
    zero |=> (shown == '0));
endmodule

// File: rtl/stopwatch_core.sv
module stopwatch_core #(
  parameter int          PRE_STAGES  = 3,
  parameter int unsigned MIN_LO_LAST = 9,
  parameter int unsigned MIN_HI_LAST = 9
) (
  input  logic        clk,
  input  logic        init,
  input  logic        run_en,
  input  logic        clr,
  input  logic        lap_hold,
  output logic [23:0] live_bcd,
  output logic [23:0] shown_bcd
);
  import sw_pkg::*;

  logic          zero;
  logic          tick;
  logic [NDIG:0] carry;
  logic [DW-1:0] dq   [NDIG];
  logic [DW-1:0] dnx  [NDIG];
  logic [NDIG-1:0] dlast;
  logic [OW-1:0] live_next;

  assign zero = init || clr;

  sw_prescale #(.STAGES(PRE_STAGES)) pre_i (
    .clk (clk),
    .zero(zero),
    .en  (run_en),
    .tick(tick)
  );

  assign carry[0] = tick;

  generate
    for (genvar i = 0; i < NDIG; i++) begin : g_dig
      localparam int unsigned L = stage_last(i, MIN_LO_LAST, MIN_HI_LAST);
      sw_digit #(.LAST(L)) dig_i (
        .clk    (clk),
        .zero   (zero),
        .step   (carry[i]),
        .q      (dq[i]),
        .q_next (dnx[i]),
        .at_last(dlast[i])
      );
      assign carry[i+1]            = carry[i] && dlast[i];
      assign live_bcd[i*DW +: DW]  = dq[i];
      assign live_next[i*DW +: DW] = dnx[i];
    end
  endgenerate

  sw_lap_hold #(.W(OW)) hold_i (
    .clk     (clk),
    .zero    (zero),
    .freeze  (lap_hold),
    .next_val(live_next),
    .shown   (shown_bcd)
  );

  // R9: unfrozen display equals the live count after the edge
  a_r9_follow: assert property (@(posedge clk) disable iff (init)
    (!lap_hold && !clr) |=> (shown_bcd == live_bcd));
  // R7: clear empties the live count at once
  a_r7_clear_live: assert property (@(posedge clk)
    clr |=> (live_bcd == '0));
  // R3: paused counter keeps its value
  a_r3_paused: assert property (@(posedge clk) disable iff (zero)
    !run_en |=> $stable(live_bcd));
  // R1: init empties everything
  a_r1_init: assert property (@(posedge clk)
    init |=> (live_bcd == '0 && shown_bcd == '0));
endmodule

// File: tb/stopwatch_core_tb_top.sv
module stopwatch_core_tb_top;
  localparam int S_DIV = 1000;
  localparam int S_N   = 600000;
  localparam int F_DIV = 1;
  localparam int F_N   = 12000;

  logic clk = 1'b0;
  logic init = 1'b1, run_en = 1'b0, clr = 1'b0, lap = 1'b0;
  logic [23:0] live_s, shown_s, live_f, shown_f;

  int total = 0, bad = 0, cyc = 0;
  bit armed = 1'b0, done = 1'b0;
  string cur_req = "R1";

  int s_pre = 0, s_tot = 0, s_held = 0;
  int f_pre = 0, f_tot = 0, f_held = 0;

  always #5 clk = ~clk;

  stopwatch_core dut_i (
    .clk(clk), .init(init), .run_en(run_en), .clr(clr), .lap_hold(lap),
    .live_bcd(live_s), .shown_bcd(shown_s)
  );

  stopwatch_core #(.PRE_STAGES(0), .MIN_LO_LAST(1), .MIN_HI_LAST(0)) fast_i (
    .clk(clk), .init(init), .run_en(run_en), .clr(clr), .lap_hold(lap),
    .live_bcd(live_f), .shown_bcd(shown_f)
  );

  function automatic logic [23:0] to_bcd(int t, int lo_mod);
    int h, s, m;
    h = t % 100;
    s = (t / 100) % 60;
    m = t / 6000;
    return {4'(m / lo_mod), 4'(m % lo_mod), 4'(s / 10), 4'(s % 10),
            4'(h / 10), 4'(h % 10)};
  endfunction

  task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural elapsed-time model
  always @(posedge clk) begin
    cyc++;
    if (init || clr) begin
      s_pre = 0; s_tot = 0; s_held = 0;
      f_pre = 0; f_tot = 0; f_held = 0;
    end else begin
      if (run_en) begin
        if (s_pre == S_DIV - 1) s_tot = (s_tot + 1) % S_N;
        s_pre = (s_pre + 1) % S_DIV;
        if (f_pre == F_DIV - 1) f_tot = (f_tot + 1) % F_N;
        f_pre = (f_pre + 1) % F_DIV;
      end
      if (!lap) begin
        s_held = s_tot;
        f_held = f_tot;
      end
    end
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      chk(cur_req, live_s,  to_bcd(s_tot, 10));
      chk(cur_req, shown_s, to_bcd(s_held, 10));
      chk(cur_req, live_f,  to_bcd(f_tot, 2));
      chk(cur_req, shown_f, to_bcd(f_held, 2));
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", live_s, 24'h0);  chk("R1", shown_s, 24'h0);
    chk("R1", live_f, 24'h0);  chk("R1", shown_f, 24'h0);
    init = 1'b0;
    armed = 1'b1;

    cur_req = "R2";
    run_en = 1'b1;
    repeat (99) @(negedge clk);
    chk("R4", live_f, 24'h000099);
    @(negedge clk);
    chk("R4", live_f, 24'h000100);
    repeat (899) @(negedge clk);
    chk("R2", live_s, 24'h000000);
    @(negedge clk);
    chk("R2", live_s, 24'h000001);
    chk("R2", live_f, 24'h001000);

    cur_req = "R3";
    run_en = 1'b0;
    repeat (50) @(negedge clk);
    chk("R3", live_s, 24'h000001);
    chk("R3", live_f, 24'h001000);

    cur_req = "R8";
    lap = 1'b1;
    run_en = 1'b1;
    repeat (500) @(negedge clk);
    chk("R8", shown_f, 24'h001000);
    chk("R8", live_f,  24'h001500);
    chk("R8", shown_s, 24'h000001);

    cur_req = "R9";
    lap = 1'b0;
    @(negedge clk);
    chk("R9", shown_f, 24'h001501);
    chk("R9", live_f,  24'h001501);

    cur_req = "R5";
    while (f_tot != 5999) @(negedge clk);
    chk("R5", live_f, 24'h005999);
    @(negedge clk);
    chk("R5", live_f, 24'h010000);

    cur_req = "R6";
    while (f_tot != 11999) @(negedge clk);
    chk("R6", live_f, 24'h015999);
    @(negedge clk);
    chk("R6", live_f,  24'h000000);
    chk("R6", shown_f, 24'h000000);

    cur_req = "R7";
    lap = 1'b1;
    repeat (20) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    chk("R7", live_s, 24'h0);  chk("R7", shown_s, 24'h0);
    chk("R7", live_f, 24'h0);  chk("R7", shown_f, 24'h0);
    clr = 1'b0;
    lap = 1'b0;
    repeat (30) @(negedge clk);
    chk("R7", live_f, 24'h000030);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule